// File: doc/BRIEF.md
# Current-Sense Amplifier Offset Calibration Sequencer

This block sequences offset calibration for a set of current-sense amplifiers (three by default). After reset it waits until the reference voltage is reported valid. It then runs a trim on every channel at once, with every gain forced to the top setting. It declares the amplifiers ready when each channel has answered with its done handshake, or when a programmable cycle budget runs out. The analog trim is not modelled here: each amplifier is only a request line out and a done pulse back.

After power-up, software sets a per-channel calibration bit to start a run on that channel. If the auto-calibration enable input is low, the run is manual: the selected channels have their inputs shorted and their load disconnected, and they keep their programmed gain. If the enable is high, the run is a run-time automatic trim. The selected channels are calibrated and every channel is forced to maximum gain, with no switch forcing, so the run can proceed while the bridges keep switching. When the run ends, the programmed gain and the switches are restored and the bits of the channels that took part clear themselves. An overrun of the cycle budget raises a timeout flag, which is cleared when the next run starts.

Top module: `csa_cal_ctrl`

## Requirements
- R1: Out of reset, busy, ready, err_timeout, cal_bits, amp_cal, in_short and load_dis are all 0, and gain_out equals gain_cfg.
- R2: No calibration starts while ref_ok is low. One cycle after ref_ok is seen high, a power-up run starts: busy=1, amp_cal all ones, every gain_out field 2'b11, in_short and load_dis 0.
- R3: The power-up run ends once every channel has given an amp_done pulse, in any order and in separate cycles. Then busy=0 and ready=1, and ready stays 1.
- R4: A run in which the selected channels have not all answered lasts exactly timeout_lim+1 cycles. It then ends with err_timeout=1. The flag is cleared in the cycle the next run starts.
- R5: A one-cycle pulse on cal_req[i] sets cal_bits[i] on the next cycle. The bit stays set until the run that includes channel i ends.
- R6: With auto_en=0, a run starts one cycle after cal_bits becomes nonzero. For the selected channels only, amp_cal, in_short and load_dis are 1, and gain_out stays equal to gain_cfg.
- R7: With auto_en=1, the selected channels get amp_cal=1, all gain_out fields are 2'b11, and in_short and load_dis stay 0.
- R8: When a run ends, the outputs return to idle and the cal_bits of the channels in that run clear. A request that arrives during a run stays set and starts the next run one cycle after the end.
- R9: An amp_done pulse from a channel that is not in the current run does not end the run.
- R10: The gain code per channel, 2 bits at [2i+1:2i], maps 0,1,2,3 to gains 5,10,20,40. When no gain is forced, each code passes through to gain_out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_ok | input | 1 | Reference voltage above its minimum operating level |
| auto_en | input | 1 | Selects run-time automatic calibration for requested runs |
| cal_req | input | NCH | Per-channel pulse that sets the calibration bit |
| gain_cfg | input | 2*NCH | Programmed gain code per channel |
| timeout_lim | input | CNT_W | Cycle budget for a run |
| amp_done | input | NCH | Trim-complete pulse from each amplifier |
| cal_bits | output | NCH | Per-channel calibration bits (self-clearing) |
| amp_cal | output | NCH | Calibration mode request to each amplifier |
| in_short | output | NCH | Short the amplifier inputs together |
| load_dis | output | NCH | Disconnect the amplifier load |
| gain_out | output | 2*NCH | Gain code applied to each amplifier |
| busy | output | 1 | A calibration run is in progress |
| ready | output | 1 | Power-up calibration has finished |
| err_timeout | output | 1 | The last run hit its cycle budget |

## Verification
The bench sweeps every nonempty channel mask in both manual and automatic runs, with the programmed gain codes rotated across channels. A design that forced gain in manual mode, shorted the inputs in automatic mode, or touched unselected channels would show up on gain_out, in_short and amp_cal. The bench gives done pulses from channels outside the run, which catches a completion check that ignores the mask. It measures the timeout window at several budgets, including zero, to catch an off-by-one in the counter. It raises a request in the middle of a run to show that the end-of-run clear removes only the channels that took part, and that the pending channel starts right afterwards.

// File: rtl/csa_cal_pkg.sv
package csa_cal_pkg;
    localparam int GAIN_W = 2;
    localparam logic [GAIN_W-1:0] GAIN_MAX_CODE = '1;

    typedef enum logic [2:0] {
        ST_WAIT_REF,
        ST_PWRUP,
        ST_IDLE,
        ST_MANUAL,
        ST_AUTO
    } cal_state_e;
endpackage

// File: rtl/csa_cal_timer.sv
module csa_cal_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic [CNT_W-1:0] lim,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = '0;
        end else if (run && (cnt_q != '1)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run && (cnt_q >= lim);
endmodule

// File: rtl/csa_cal_seq.sv
module csa_cal_seq
    import csa_cal_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ref_ok,
    input  logic           auto_en,
    input  logic [NCH-1:0] cal_req,
    input  logic [NCH-1:0] amp_done,
    input  logic           expired,
    output logic           start,
    output logic           run,
    output logic           manual,
    output logic           force_max,
    output logic [NCH-1:0] mask,
    output logic [NCH-1:0] bits,
    output logic           ready,
    output logic           err
);
    typedef struct packed {
        cal_state_e     st;
        logic [NCH-1:0] mask;
        logic [NCH-1:0] done;
        logic [NCH-1:0] bits;
        logic           ready;
        logic           err;
    } seq_t;

    seq_t           s_d, s_q;
    logic [NCH-1:0] clr;
    logic           all_in;

    always_comb begin
        s_d    = s_q;
        start  = 1'b0;
        clr    = '0;
        all_in = ((s_q.done | amp_done) & s_q.mask) == s_q.mask;
        unique case (s_q.st)
            ST_WAIT_REF: begin
                if (ref_ok) begin
                    s_d.st   = ST_PWRUP;
                    s_d.mask = '1;
                    s_d.done = '0;
                    start    = 1'b1;
                end
            end
            ST_IDLE: begin
                if (|s_q.bits) begin
                    s_d.st   = auto_en ? ST_AUTO : ST_MANUAL;
                    s_d.mask = s_q.bits;
                    s_d.done = '0;
                    s_d.err  = 1'b0;
                    start    = 1'b1;
                end
            end
            default: begin
                s_d.done = s_q.done | (amp_done & s_q.mask);
                if (all_in || expired) begin
                    s_d.st = ST_IDLE;
                    if (s_q.st == ST_PWRUP) s_d.ready = 1'b1;
                    else                    clr       = s_q.mask;
                    if (!all_in) s_d.err = 1'b1;
                end
            end
        endcase
        s_d.bits = (s_q.bits & ~clr) | cal_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st    <= ST_WAIT_REF;
            s_q.mask  <= '0;
            s_q.done  <= '0;
            s_q.bits  <= '0;
            s_q.ready <= 1'b0;
            s_q.err   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign run       = (s_q.st == ST_PWRUP) || (s_q.st == ST_MANUAL) || (s_q.st == ST_AUTO);
    assign manual    = (s_q.st == ST_MANUAL);
    assign force_max = (s_q.st == ST_PWRUP) || (s_q.st == ST_AUTO);
    assign mask      = s_q.mask;
    assign bits      = s_q.bits;
    assign ready     = s_q.ready;
    assign err       = s_q.err;
endmodule

// File: rtl/csa_cal_chan.sv
module csa_cal_chan
    import csa_cal_pkg::*;
(
    input  logic              active,
    input  logic              manual,
    input  logic              force_max,
    input  logic [GAIN_W-1:0] gain_cfg,
    output logic              amp_cal,
    output logic              in_short,
    output logic              load_dis,
    output logic [GAIN_W-1:0] gain
);
    always_comb begin
        amp_cal  = active;
        in_short = active && manual;
        load_dis = active && manual;
        gain     = force_max ? GAIN_MAX_CODE : gain_cfg;
    end
endmodule

// File: rtl/csa_cal_ctrl.sv
module csa_cal_ctrl
    import csa_cal_pkg::*;
#(
    parameter int NCH   = 3,
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ref_ok,
    input  logic                  auto_en,
    input  logic [NCH-1:0]        cal_req,
    input  logic [GAIN_W*NCH-1:0] gain_cfg,
    input  logic [CNT_W-1:0]      timeout_lim,
    input  logic [NCH-1:0]        amp_done,
    output logic [NCH-1:0]        cal_bits,
    output logic [NCH-1:0]        amp_cal,
    output logic [NCH-1:0]        in_short,
    output logic [NCH-1:0]        load_dis,
    output logic [GAIN_W*NCH-1:0] gain_out,
    output logic                  busy,
    output logic                  ready,
    output logic                  err_timeout
);
    logic           start, run, manual, force_max, expired;
    logic [NCH-1:0] mask;

    csa_cal_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .run     (run),
        .lim     (timeout_lim),
        .expired (expired)
    );

    csa_cal_seq #(.NCH(NCH)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_ok    (ref_ok),
        .auto_en   (auto_en),
        .cal_req   (cal_req),
        .amp_done  (amp_done),
        .expired   (expired),
        .start     (start),
        .run       (run),
        .manual    (manual),
        .force_max (force_max),
        .mask      (mask),
        .bits      (cal_bits),
        .ready     (ready),
        .err       (err_timeout)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        csa_cal_chan u_ch (
            .active    (run && mask[i]),
            .manual    (manual),
            .force_max (force_max),
            .gain_cfg  (gain_cfg[i*GAIN_W +: GAIN_W]),
            .amp_cal   (amp_cal[i]),
            .in_short  (in_short[i]),
            .load_dis  (load_dis[i]),
            .gain      (gain_out[i*GAIN_W +: GAIN_W])
        );
    end

    assign busy = run;
endmodule

// File: rtl/csa_cal_ctrl_chk.sv
module csa_cal_ctrl_chk
    import csa_cal_pkg::*;
#(
    parameter int NCH = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [GAIN_W*NCH-1:0] gain_cfg,
    input logic [NCH-1:0]        cal_bits,
    input logic [NCH-1:0]        amp_cal,
    input logic [NCH-1:0]        in_short,
    input logic [NCH-1:0]        load_dis,
    input logic [GAIN_W*NCH-1:0] gain_out,
    input logic                  busy,
    input logic                  ready,
    input logic                  err_timeout
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (amp_cal == '0) && (in_short == '0) && (load_dis == '0));

    assert_ready_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    assert_err_at_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_timeout) |-> $fell(busy));

    assert_bits_clear_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(cal_bits) & ~cal_bits)) |-> $fell(busy));

    assert_manual_keeps_gain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|in_short) |-> (gain_out == gain_cfg) && ((in_short & ~amp_cal) == '0));

    assert_auto_forces_gain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((|amp_cal) && (in_short == '0)) |-> (gain_out == {NCH{GAIN_MAX_CODE}}));

    assert_switch_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_short == load_dis);
endmodule

bind csa_cal_ctrl csa_cal_ctrl_chk #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .gain_cfg    (gain_cfg),
    .cal_bits    (cal_bits),
    .amp_cal     (amp_cal),
    .in_short    (in_short),
    .load_dis    (load_dis),
    .gain_out    (gain_out),
    .busy        (busy),
    .ready       (ready),
    .err_timeout (err_timeout)
);

// File: tb/csa_cal_ctrl_test.sv
module csa_cal_ctrl_test;
    localparam int NCH = 3;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ref_ok = 1'b0;
    logic             auto_en = 1'b0;
    logic [NCH-1:0]   cal_req = '0;
    logic [2*NCH-1:0] gain_cfg = '0;
    logic [CNT_W-1:0] timeout_lim = 16'd20;
    logic [NCH-1:0]   amp_done = '0;
    logic [NCH-1:0]   cal_bits, amp_cal, in_short, load_dis;
    logic [2*NCH-1:0] gain_out;
    logic             busy, ready, err_timeout;

    int errors = 0;
    int checks = 0;

    csa_cal_ctrl #(.NCH(NCH), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .ref_ok(ref_ok), .auto_en(auto_en),
        .cal_req(cal_req), .gain_cfg(gain_cfg), .timeout_lim(timeout_lim),
        .amp_done(amp_done), .cal_bits(cal_bits), .amp_cal(amp_cal),
        .in_short(in_short), .load_dis(load_dis), .gain_out(gain_out),
        .busy(busy), .ready(ready), .err_timeout(err_timeout)
    );

    always #10 clk = ~clk;

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2*NCH-1:0] rot_gain(input int g);
        logic [2*NCH-1:0] v;
        for (int i = 0; i < NCH; i++) v[2*i +: 2] = 2'((g + i) % 4);
        return v;
    endfunction

    task automatic request(input logic [NCH-1:0] m);
        cal_req = m;
        step();
        cal_req = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        gain_cfg = rot_gain(1);
        repeat (3) @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 ready", ready, 0);
        chk("R1 outs", {err_timeout, cal_bits, amp_cal, in_short, load_dis}, 0);
        chk("R1 gain", gain_out, rot_gain(1));
        rst_n = 1'b1;
        repeat (10) step();
        chk("R2 no start without ref", {busy, amp_cal}, 0);

        ref_ok = 1'b1;
        step();
        chk("R2 pwrup busy", busy, 1);
        chk("R2 pwrup amp_cal", amp_cal, 3'b111);
        chk("R2 pwrup gain max", gain_out, 6'h3F);
        chk("R2 pwrup no switches", {in_short, load_dis}, 0);
        amp_done = 3'b100; step();
        amp_done = 3'b001; step();
        amp_done = 3'b000; step();
        chk("R3 still busy with two done", busy, 1);
        amp_done = 3'b010; step();
        amp_done = '0;
        chk("R3 pwrup done", {busy, ready, err_timeout}, 3'b010);

        for (int g = 0; g < 4; g++) begin
            gain_cfg = rot_gain(g);
            #1;
            chk("R10 gain passthrough", gain_out, rot_gain(g));
        end

        for (int m = 1; m < 8; m++) begin
            for (int a = 0; a < 2; a++) begin
                logic [NCH-1:0] mk;
                mk = 3'(m);
                auto_en = 1'(a);
                gain_cfg = rot_gain(m + a);
                request(mk);
                chk("R5 bits set", cal_bits, mk);
                step();
                chk(a ? "R7 amp_cal" : "R6 amp_cal", amp_cal, mk);
                chk(a ? "R7 switches" : "R6 switches", {in_short, load_dis},
                    a ? 6'd0 : {mk, mk});
                chk(a ? "R7 gain forced" : "R6 gain kept", gain_out,
                    a ? 6'h3F : rot_gain(m + a));
                if (mk != 3'b111) begin
                    amp_done = ~mk; step(); amp_done = '0;
                    chk("R9 foreign done ignored", busy, 1);
                    chk("R5 bits held", cal_bits, mk);
                end
                amp_done = mk; step(); amp_done = '0;
                chk("R8 run ended", {busy, err_timeout, cal_bits, amp_cal, in_short, load_dis}, 0);
                chk("R8 gain restored", gain_out, rot_gain(m + a));
            end
        end

        auto_en = 1'b0;
        foreach (timeout_lim_set[k]) begin end
        for (int k = 0; k < 4; k++) begin
            int lim, n;
            lim = (k == 0) ? 0 : (1 << k) - 1;
            timeout_lim = 16'(lim);
            request(3'b001);
            step();
            n = 0;
            while (busy && n < 100) begin n++; step(); end
            chk("R4 window length", n, lim + 1);
            chk("R4 err set", err_timeout, 1);
            chk("R4 bit cleared", cal_bits, 0);
        end
        timeout_lim = 16'd20;
        request(3'b100);
        step();
        chk("R4 err cleared on start", {busy, err_timeout}, 2'b10);
        amp_done = 3'b100; step(); amp_done = '0;

        request(3'b001);
        step();
        request(3'b010);
        chk("R8 pending bits", cal_bits, 3'b011);
        chk("R8 run keeps mask", amp_cal, 3'b001);
        amp_done = 3'b001; step(); amp_done = '0;
        chk("R8 end keeps pending", {busy, cal_bits}, 4'b0010);
        step();
        chk("R8 pending starts", {busy, amp_cal}, 4'b1010);
        amp_done = 3'b010; step(); amp_done = '0;
        chk("R8 all clear", {busy, cal_bits, err_timeout}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    int timeout_lim_set[1];
endmodule